// File: doc/BRIEF.md
# Split-Transaction Timeout Register Block

This block is a small control and status register set for a node on a serial bus. It holds a split-transaction timeout as two words: a high word that carries whole seconds and a low word whose upper 13 bits carry a fraction of a second. The fraction is counted in bus cycles of 125 microseconds, so 8000 cycles make one second. The block also holds a state word. That word has one offset that sets bits and another that clears them.

A host reaches the registers through a plain 32-bit write strobe, a byte offset and a combinational read-data output. Every write to the low word is saturated, so the fraction always lies between 800 cycles (100 ms) and 7999 cycles. The two words merge into one cycle count, which is shown on a dedicated output. That count also sets the limit for an on-board timer. The timer is armed by a transaction-start pulse and advances on each bus-cycle tick. It raises a one-cycle expiry pulse unless the transaction completes first.

Top module: `sto_csr_top`

## Requirements
- R1: After reset the state word is 0, the high word reads 0, the low word reads 800<<19 (0x19000000), the cycle count output is 800, and the timer is idle.
- R2: A write at byte offset 0x004 ORs the written bits into the state word. A read at offset 0x004 or offset 0x000 returns the current state word.
- R3: A write at byte offset 0x000 clears each state bit that is 1 in the written data and leaves the other bits unchanged.
- R4: A write at byte offset 0x01C takes bits 31:19 as the fraction and saturates it into 800..7999 (below 800 gives 800, above 7999 gives 7999). Reads at 0x01C return the fraction in bits 31:19 and zero in bits 18:0.
- R5: A write at byte offset 0x018 keeps only bits 2:0 as seconds. Reads at 0x018 return the seconds in bits 2:0 and zero in bits 31:3.
- R6: The cycle count output equals seconds*8000 + fraction. Each word updates on its own write, one cycle after the write, with no pairing between the two words.
- R7: A write at any offset other than 0x000, 0x004, 0x018 and 0x01C changes no register. A read at such an offset returns 0.
- R8: A start pulse arms the timer with a count of 0. Each tick while armed adds one to the count. The tick that brings the count to the cycle count output causes the expiry output to be 1 for exactly one cycle, and in that same cycle the busy output returns to 0.
- R9: A done pulse while armed disarms the timer without an expiry, and later ticks cause no expiry.
- R10: A start pulse while armed restarts the count from 0. Start takes priority over done and tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| txn_start | input | 1 | Arms the timer for a new pending transaction |
| txn_done | input | 1 | The pending transaction completed |
| cycle_tick | input | 1 | One pulse per 125 us bus cycle |
| timeout_cycles | output | 16 | Effective timeout in bus cycles |
| txn_busy | output | 1 | Timer armed |
| txn_expired | output | 1 | One-cycle timeout pulse |

## Verification
The low word is written with fractions below, inside and above the legal window, including the exact values 800, 7999 and 8000 and the all-ones field, with junk in the low bits. These patterns separate saturation at each end from pass-through and from the masking of bits 18:0. The high word is written with all upper bits set and then with the largest seconds value, which shows the masking and the full-scale merge to 63999. The timer is run to completion, stopped one tick short, cancelled by done, and restarted mid-count. These runs separate counting from arming, expiry at exactly the limit from expiry after it, and a restarted count from a continued one.

// File: rtl/sto_pkg.sv
package sto_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int SEC_W       = 3;
    localparam int FRAC_W      = 13;
    localparam int FRAC_LSB    = DATA_W - FRAC_W;
    localparam int FRAC_MIN    = 800;
    localparam int FRAC_MAX    = 7999;
    localparam int CYC_PER_SEC = 8000;
    localparam int CYC_W       = 16;

    localparam logic [ADDR_W-1:0] OFS_CLR = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SET = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_HI  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_LO  = 12'h01C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLR,
        SEL_SET,
        SEL_HI,
        SEL_LO
    } reg_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [FRAC_W-1:0] frac;
    } split_to_t;

    function automatic logic [FRAC_W-1:0] clamp_frac(input logic [FRAC_W-1:0] raw);
        if (raw < FRAC_W'(FRAC_MIN))      return FRAC_W'(FRAC_MIN);
        else if (raw > FRAC_W'(FRAC_MAX)) return FRAC_W'(FRAC_MAX);
        else                              return raw;
    endfunction

    function automatic logic [CYC_W-1:0] to_cycles(input split_to_t t);
        return CYC_W'(t.sec) * CYC_W'(CYC_PER_SEC) + CYC_W'(t.frac);
    endfunction

endpackage

// File: rtl/sto_addr_decode.sv
module sto_addr_decode
    import sto_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFS_CLR: sel = SEL_CLR;
            OFS_SET: sel = SEL_SET;
            OFS_HI:  sel = SEL_HI;
            OFS_LO:  sel = SEL_LO;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sto_regs.sv
module sto_regs
    import sto_pkg::*;
#(
    parameter int STATE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  reg_sel_e           rd_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output split_to_t          split_q
);
    logic [STATE_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= '0;
            split_q.sec  <= '0;
            split_q.frac <= FRAC_W'(FRAC_MIN);
        end else if (wr_en) begin
            case (wr_sel)
                SEL_SET: state_q      <= state_q | wdata[STATE_W-1:0];
                SEL_CLR: state_q      <= state_q & ~wdata[STATE_W-1:0];
                SEL_HI:  split_q.sec  <= wdata[SEC_W-1:0];
                SEL_LO:  split_q.frac <= clamp_frac(wdata[DATA_W-1:FRAC_LSB]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rd_sel)
            SEL_SET, SEL_CLR: rdata[STATE_W-1:0]        = state_q;
            SEL_HI:           rdata[SEC_W-1:0]          = split_q.sec;
            SEL_LO:           rdata[DATA_W-1:FRAC_LSB]  = split_q.frac;
            default:          rdata = '0;
        endcase
    end

    // R2
    p_set_or_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SET) |=>
            state_q == ($past(state_q) | $past(wdata[STATE_W-1:0])));
    // R3
    p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CLR) |=>
            state_q == ($past(state_q) & ~$past(wdata[STATE_W-1:0])));
    // R4
    p_frac_range_r4: assert property (@(posedge clk) disable iff (rst)
        (split_q.frac >= FRAC_W'(FRAC_MIN)) && (split_q.frac <= FRAC_W'(FRAC_MAX)));
    // R5
    p_sec_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HI) |=> split_q.sec == $past(wdata[SEC_W-1:0]));
    // R7
    p_unmapped_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(state_q) && $stable(split_q)));
endmodule

// File: rtl/sto_timer.sv
module sto_timer
    import sto_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done,
    input  logic             tick,
    input  logic [CYC_W-1:0] limit,
    output logic             busy,
    output logic             expired
);
    logic [CYC_W-1:0] cnt_q;
    logic [CYC_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + CYC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            expired <= 1'b0;
            cnt_q   <= '0;
        end else begin
            expired <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end else if (done) begin
                busy <= 1'b0;
            end else if (busy && tick) begin
                cnt_q <= cnt_nx;
                if (cnt_nx >= limit) begin
                    busy    <= 1'b0;
                    expired <= 1'b1;
                end
            end
        end
    end

    // R8
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);
    // R8
    p_pulse_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        expired |-> !busy);
    // R9
    p_done_cancels_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (!busy && !expired));
    // R10
    p_start_arms_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !expired));
endmodule

// File: rtl/sto_csr_top.sv
module sto_csr_top
    import sto_pkg::*;
#(
    parameter int STATE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                txn_start,
    input  logic                txn_done,
    input  logic                cycle_tick,
    output logic [CYC_W-1:0]    timeout_cycles,
    output logic                txn_busy,
    output logic                txn_expired
);
    reg_sel_e  sel;
    split_to_t split_q;

    sto_addr_decode u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    sto_regs #(.STATE_W(STATE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_sel  (sel),
        .rd_sel  (sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .split_q (split_q)
    );

    assign timeout_cycles = to_cycles(split_q);

    sto_timer u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (txn_start),
        .done    (txn_done),
        .tick    (cycle_tick),
        .limit   (timeout_cycles),
        .busy    (txn_busy),
        .expired (txn_expired)
    );

    // R6
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_cycles <= CYC_W'(SEC_W'('1) * CYC_PER_SEC + FRAC_MAX)
        && timeout_cycles >= CYC_W'(FRAC_MIN));
endmodule

// File: tb/test_sto_csr_top.sv
`timescale 1ns/1ps
module test_sto_csr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_start = 1'b0, txn_done = 1'b0, cycle_tick = 1'b0;
    logic [15:0] timeout_cycles;
    logic        txn_busy, txn_expired;

    int n_chk = 0, n_fail = 0, pulse_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        int          sel;   // 0 rdata, 1 timeout_cycles, 2 expired, 3 busy
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    sto_csr_top i_sto_csr_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_start(txn_start),
        .txn_done(txn_done), .cycle_tick(cycle_tick),
        .timeout_cycles(timeout_cycles), .txn_busy(txn_busy),
        .txn_expired(txn_expired)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] lo_word(input int frac);
        int f = frac;
        if (f < 800) f = 800;
        if (f > 7999) f = 7999;
        return 32'(f) << 19;
    endfunction

    task automatic expect_item(input string req, input int sel, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected items away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                0: act = reg_rdata;
                1: act = 32'(timeout_cycles);
                2: act = 32'(txn_expired);
                default: act = 32'(txn_busy);
            endcase
            check(it.req, act, it.exp);
        end
        if (txn_expired) pulse_cnt++;
    end

    task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit st, input bit dn, input bit tk);
        @(negedge clk); #2;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        txn_start = st; txn_done = dn; cycle_tick = tk;
        @(posedge clk); #1;
        reg_wr = 1'b0; txn_start = 1'b0; txn_done = 1'b0; cycle_tick = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_expect(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk); #2;
        reg_addr = a;
        #1 expect_item(req, 0, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, reg_addr, '0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_expect("R1 state", 12'h000, 32'h0);
        rd_expect("R1 hi", 12'h018, 32'h0);
        rd_expect("R1 lo", 12'h01C, 32'h1900_0000);
        expect_item("R1 cycles", 1, 32'd800);
        expect_item("R1 busy", 3, 32'd0);

        // R2 set / R3 clear
        wr(12'h004, 32'hA5A5_0F0F);
        rd_expect("R2 set read 0x004", 12'h004, 32'hA5A5_0F0F);
        wr(12'h004, 32'h0000_F000);
        rd_expect("R2 set OR read 0x000", 12'h000, 32'hA5A5_FF0F);
        wr(12'h000, 32'hFF00_000F);
        rd_expect("R3 clear bits", 12'h004, 32'h00A5_FF00);

        // R7 unmapped offsets
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h005, 32'h0000_0000);
        wr(12'h01D, 32'h0000_0000);
        rd_expect("R7 state untouched", 12'h000, 32'h00A5_FF00);
        rd_expect("R7 lo untouched", 12'h01C, 32'h1900_0000);
        rd_expect("R7 unmapped reads zero", 12'h008, 32'h0);

        // R4 clamp
        wr(12'h01C, 32'(8000) << 19);
        rd_expect("R4 8000 to 7999", 12'h01C, lo_word(7999));
        wr(12'h01C, (32'(5) << 19) | 32'h7FFFF);
        rd_expect("R4 low to 800", 12'h01C, lo_word(800));
        wr(12'h01C, 32'hFFF8_0000);
        rd_expect("R4 all ones to 7999", 12'h01C, lo_word(7999));
        wr(12'h01C, (32'(1000) << 19) | 32'h5A5A5);
        rd_expect("R4 in range, low bits zero", 12'h01C, lo_word(1000));
        expect_item("R6 cycles 1000", 1, 32'd1000);
        wr(12'h01C, 32'(799) << 19);
        rd_expect("R4 799 to 800", 12'h01C, lo_word(800));

        // R5 hi masking
        wr(12'h018, 32'hFFFF_FFFD);
        rd_expect("R5 hi masked", 12'h018, 32'd5);
        expect_item("R6 5s+800", 1, 32'd40800);
        wr(12'h018, 32'd7);
        wr(12'h01C, 32'(7999) << 19);
        expect_item("R6 full scale", 1, 32'd63999);
        wr(12'h018, 32'd0);
        expect_item("R6 hi alone", 1, 32'd7999);
        wr(12'h01C, 32'(800) << 19);
        expect_item("R6 back to 800", 1, 32'd800);

        // R8 run to expiry at exactly 800 ticks
        ticks(5);
        expect_item("R8 ticks without start", 3, 32'd0);
        step(1'b0, reg_addr, '0, 1'b1, 1'b0, 1'b0);
        expect_item("R8 armed", 3, 32'd1);
        base = pulse_cnt;
        ticks(799);
        expect_item("R8 busy one short", 3, 32'd1);
        expect_item("R8 no pulse one short", 2, 32'd0);
        ticks(1);
        expect_item("R8 pulse at limit", 2, 32'd1);
        expect_item("R8 busy drops", 3, 32'd0);
        step(1'b0, reg_addr, '0, 1'b0, 1'b0, 1'b1);
        expect_item("R8 pulse one cycle", 2, 32'd0);
        ticks(3);
        check("R8 exactly one pulse", 32'(pulse_cnt - base), 32'd1);

        // R9 done cancels
        base = pulse_cnt;
        step(1'b0, reg_addr, '0, 1'b1, 1'b0, 1'b0);
        ticks(400);
        step(1'b0, reg_addr, '0, 1'b0, 1'b1, 1'b1);
        expect_item("R9 done disarms", 3, 32'd0);
        ticks(600);
        check("R9 no pulse after done", 32'(pulse_cnt - base), 32'd0);

        // R10 restart
        base = pulse_cnt;
        step(1'b0, reg_addr, '0, 1'b1, 1'b0, 1'b0);
        ticks(500);
        step(1'b0, reg_addr, '0, 1'b1, 1'b1, 1'b1);
        expect_item("R10 start wins", 3, 32'd1);
        ticks(799);
        check("R10 no pulse before restarted limit", 32'(pulse_cnt - base), 32'd0);
        ticks(1);
        expect_item("R10 pulse after restart", 2, 32'd1);
        ticks(2);
        check("R10 one pulse total", 32'(pulse_cnt - base), 32'd1);

        @(negedge clk); @(negedge clk);
        summary();
    end
endmodule